// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers interrupt sources into six banks of 32 lines and drives one interrupt output for each bank. Each bank has a mask register and a pending register on a 32-bit word-addressed register port. When a line rises while its mask bit is set, the matching pending bit latches. Output n is the OR of bank n's pending bits that are also unmasked. Software acknowledges an event by writing ones to the pending register.

The register window is 1 KiB. The mask/pending pairs sit on a 16-byte stride starting at byte offset 0x100. All other aligned offsets below 0x3D8 are plain read/write storage. Offsets at or above 0x3D8 read as zero and discard writes. A read is registered: the data appears on the read bus one cycle after the read strobe.

Top module: `irq_bank_aggr`

## Requirements
- R1: Output n depends only on bank n. It is high while any bit of (pending_n AND mask_n) is set, and it goes low in the cycle after the last such bit is acknowledged or masked.
- R2: For bank n (0..5), the mask register is at byte offset 0x100 + 0x10*n and the pending register is at 0x104 + 0x10*n. Line k of bank n is input bit n*32 + k and register bit k.
- R3: A pending bit latches when its line goes from 0 to 1 while its mask bit is set. A rising edge on a masked line is never latched, and neither is a line that is already high when its mask bit is later set.
- R4: In a write to a pending register, each 1 bit clears that pending bit and each 0 bit leaves it unchanged. If a new latch and an acknowledge hit the same bit in the same cycle, the latch wins.
- R5: If a line is still high and still unmasked after its pending bit is acknowledged, the bit latches again on the following clock edge.
- R6: A write to a mask register replaces the whole mask. Masking a bit does not clear its pending bit, which can still be read.
- R7: A write to any other aligned offset below 0x3D8 stores the data unchanged, and a later read returns it.
- R8: A read at an offset of 0x3D8 or above returns zero. A write there changes nothing.
- R9: An access whose two low address bits are not zero is invalid. Its write changes nothing and its read returns zero.
- R10: After reset every mask, pending and storage register is zero and every output is low.
- R11: Read data is updated on the clock edge that samples the read strobe high. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | 192 | Interrupt lines, bank n at bits n*32+31..n*32 |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_out | output | 6 | One interrupt output per bank |

## Verification
The embedded properties assume that interrupt lines and bus signals are synchronous to clk and stable around its rising edge. They also assume that reset is held for at least one edge before any access. The stimulus changes every input only after the falling edge and holds reset for four cycles. The bench never asserts read and write in the same cycle, so each read checks a state that no write in the same cycle has touched. Random line toggles, mask writes, acknowledges, storage writes, out-of-range accesses and misaligned accesses are mixed with directed sequences. The directed sequences cover acknowledging a line that is still held high, masking a bit that is pending, and enabling a line that is already high.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_ENABLE  = 2'd1,
        ACC_STATUS  = 2'd2,
        ACC_SCRATCH = 2'd3
    } acc_kind_e;

    // Classify a byte offset into the kind of register it reaches.
    function automatic acc_kind_e classify(input int unsigned off,
                                           input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned groups,
                                           input int unsigned limit);
        int unsigned rel;
        rel = off - base;
        if ((off % 4) != 0 || off >= limit)
            return ACC_NONE;
        if (off >= base && rel < groups * stride) begin
            if ((rel % stride) == 0)
                return ACC_ENABLE;
            if ((rel % stride) == 4)
                return ACC_STATUS;
        end
        return ACC_SCRATCH;
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
`timescale 1ns/1ps
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned BASE   = 'h100,
    parameter int unsigned STRIDE = 'h10,
    parameter int unsigned GROUPS = 6,
    parameter int unsigned LIMIT  = 'h3D8,
    parameter int unsigned GRP_W  = 3,
    parameter int unsigned IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [GRP_W-1:0]  grp,
    output logic [IDX_W-1:0]  word
);
    int unsigned off;

    always_comb begin
        off  = 32'(addr);
        kind = classify(off, BASE, STRIDE, GROUPS, LIMIT);
        grp  = GRP_W'((off - BASE) / STRIDE);
        word = IDX_W'(off >> 2);
    end
endmodule

// File: rtl/irq_bank_group.sv
`timescale 1ns/1ps
module irq_bank_group #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] src,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] st_q,
    output logic              irq
);
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] rearm_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] ack_vec;

    // New event: unmasked rising edge, or a held line whose bit was just acknowledged.
    assign set_vec = en_q & src & ((src & ~src_q) | rearm_q);
    assign ack_vec = st_we ? (wdata & st_q) : '0;
    assign irq     = |(st_q & en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            rearm_q <= '0;
            st_q    <= '0;
            en_q    <= '0;
        end else begin
            src_q   <= src;
            rearm_q <= ack_vec;
            st_q    <= (st_q & ~ack_vec) | set_vec;
            if (en_we)
                en_q <= wdata;
        end
    end

    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        $past(st_we) |-> ((st_q & $past(wdata) & ~$past(src)) == '0));

    assert_w0_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (($past(st_q) & ~st_q & ~($past(st_we) ? $past(wdata) : {DATA_W{1'b0}})) == '0));
endmodule

// File: rtl/irq_bank_scratch.sv
`timescale 1ns/1ps
module irq_bank_scratch #(
    parameter int unsigned WORDS  = 246,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    assign rdata = (int'(idx) < int'(WORDS)) ? mem[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(WORDS); i++)
                mem[i] <= '0;
        end else if (we && int'(idx) < int'(WORDS)) begin
            mem[idx] <= wdata;
        end
    end
endmodule

// File: rtl/irq_bank_aggr.sv
`timescale 1ns/1ps
module irq_bank_aggr
    import irq_bank_pkg::*;
#(
    parameter int unsigned GROUPS      = 6,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned PAIR_BASE   = 'h100,
    parameter int unsigned PAIR_STRIDE = 'h10,
    parameter int unsigned REG_LIMIT   = 'h3D8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [GROUPS*DATA_W-1:0] src_lines,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [GROUPS-1:0]        irq_out
);
    localparam int unsigned GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int unsigned WORDS = REG_LIMIT / 4;
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    acc_kind_e         kind;
    logic [GRP_W-1:0]  grp;
    logic [IDX_W-1:0]  word;
    logic [DATA_W-1:0] en_vec [GROUPS];
    logic [DATA_W-1:0] st_vec [GROUPS];
    logic [DATA_W-1:0] scr_rd;
    logic [DATA_W-1:0] rd_next;

    irq_bank_decode #(
        .ADDR_W(ADDR_W), .BASE(PAIR_BASE), .STRIDE(PAIR_STRIDE),
        .GROUPS(GROUPS), .LIMIT(REG_LIMIT), .GRP_W(GRP_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .grp (grp),
        .word(word)
    );

    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_bank
        irq_bank_group #(.DATA_W(DATA_W)) u_grp (
            .clk  (clk),
            .rst  (rst),
            .src  (src_lines[g*DATA_W +: DATA_W]),
            .en_we(bus_we && kind == ACC_ENABLE && grp == GRP_W'(g)),
            .st_we(bus_we && kind == ACC_STATUS && grp == GRP_W'(g)),
            .wdata(bus_wdata),
            .en_q (en_vec[g]),
            .st_q (st_vec[g]),
            .irq  (irq_out[g])
        );
    end

    irq_bank_scratch #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .we   (bus_we && kind == ACC_SCRATCH),
        .idx  (word),
        .wdata(bus_wdata),
        .rdata(scr_rd)
    );

    always_comb begin
        rd_next = '0;
        case (kind)
            ACC_ENABLE:  if (int'(grp) < int'(GROUPS)) rd_next = en_vec[grp];
            ACC_STATUS:  if (int'(grp) < int'(GROUPS)) rd_next = st_vec[grp];
            ACC_SCRATCH: rd_next = scr_rd;
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_next;
    end

    assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && ($past(bus_addr) >= ADDR_W'(REG_LIMIT))) |-> (bus_rdata == '0));

    assert_misaligned_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && ($past(bus_addr[1:0]) != 2'b00)) |-> (bus_rdata == '0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_re) |-> $stable(bus_rdata));
endmodule

// File: tb/irq_bank_aggr_tb_top.sv
`timescale 1ns/1ps
module irq_bank_aggr_tb_top;
    localparam int G   = 6;
    localparam int W   = 32;
    localparam int LIM = 'h3D8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [G*W-1:0] src_lines = '0;
    logic           bus_we = 1'b0;
    logic           bus_re = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [G-1:0]   irq_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_bank_aggr dut_i (
        .clk(clk), .rst(rst), .src_lines(src_lines),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Reference state, built from the requirements.
    logic [31:0] en_m  [G];
    logic [31:0] st_m  [G];
    logic [31:0] prv_m [G];
    logic [31:0] clr_m [G];
    logic [31:0] scr_m [LIM/4];
    logic [31:0] rd_exp = '0;
    string       rd_tag = "R10";

    // 0 none, 1 mask, 2 pending, 3 storage
    function automatic int kind_of(input logic [9:0] a);
        int o;
        o = int'(a);
        if (o % 4 != 0 || o >= LIM) return 0;
        if (o >= 'h100 && o < 'h100 + 'h10 * G) begin
            if (o % 16 == 0) return 1;
            if (o % 16 == 4) return 2;
        end
        return 3;
    endfunction

    function automatic int grp_of(input logic [9:0] a);
        return (int'(a) - 'h100) / 16;
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        case (kind_of(a))
            1: return en_m[grp_of(a)];
            2: return st_m[grp_of(a)];
            3: return scr_m[int'(a) / 4];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        case (kind_of(a))
            1: return "R6";
            2: return "R4";
            3: return "R7";
            default: return (a[1:0] != 2'b00) ? "R9" : "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [31:0] s, setv, ackv;
        if (rst) begin
            for (int g = 0; g < G; g++) begin
                en_m[g] = '0; st_m[g] = '0; prv_m[g] = '0; clr_m[g] = '0;
            end
            for (int i = 0; i < LIM/4; i++) scr_m[i] = '0;
            rd_exp = '0;
            rd_tag = "R10";
        end else begin
            if (bus_re) begin
                rd_exp = exp_read(bus_addr);
                rd_tag = tag_of(bus_addr);
            end else begin
                rd_tag = "R11";
            end
            for (int g = 0; g < G; g++) begin
                s    = src_lines[g*W +: W];
                setv = en_m[g] & s & ((s & ~prv_m[g]) | clr_m[g]);
                ackv = (bus_we && kind_of(bus_addr) == 2 && grp_of(bus_addr) == g)
                       ? (bus_wdata & st_m[g]) : 32'h0;
                st_m[g]  = (st_m[g] & ~ackv) | setv;
                if (bus_we && kind_of(bus_addr) == 1 && grp_of(bus_addr) == g)
                    en_m[g] = bus_wdata;
                prv_m[g] = s;
                clr_m[g] = ackv;
            end
            if (bus_we && kind_of(bus_addr) == 3)
                scr_m[int'(bus_addr) / 4] = bus_wdata;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int g = 0; g < G; g++)
            chk(rst ? "R10" : "R1", {31'b0, irq_out[g]}, {31'b0, |(st_m[g] & en_m[g])});
        chk(rd_tag, bus_rdata, rd_exp);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        bus_re = 1'b1; bus_addr = a;
        tick();
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20250213));
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;
        tick();

        // R10: reset state
        chk("R10", {26'b0, irq_out}, 32'h0);
        rd('h100, v); chk("R10", v, 32'h0);
        rd('h154, v); chk("R10", v, 32'h0);
        rd('h000, v); chk("R10", v, 32'h0);

        // R2/R3: mask bank 2 bits 0 and 2, raise line 0
        wr('h120, 32'h5);
        src_lines[2*W + 0] = 1'b1;
        tick();
        chk("R1", {26'b0, irq_out}, 32'h4);
        rd('h124, v); chk("R2", v, 32'h1);
        // R3: masked line 1 pulse is not latched
        src_lines[2*W + 1] = 1'b1; tick();
        src_lines[2*W + 1] = 1'b0; tick();
        rd('h124, v); chk("R3", v, 32'h1);

        // R4: writing zero keeps, writing one clears
        wr('h124, 32'h0);
        rd('h124, v); chk("R4", v, 32'h1);
        wr('h124, 32'h1);
        chk("R4", {31'b0, irq_out[2]}, 32'h0);
        tick();
        chk("R5", {31'b0, irq_out[2]}, 32'h1);
        rd('h124, v); chk("R5", v, 32'h1);
        src_lines[2*W + 0] = 1'b0;
        wr('h124, 32'h1);
        tick();
        rd('h124, v); chk("R4", v, 32'h0);
        chk("R1", {31'b0, irq_out[2]}, 32'h0);

        // R6: masking keeps pending
        src_lines[2*W + 2] = 1'b1; tick();
        chk("R1", {31'b0, irq_out[2]}, 32'h1);
        wr('h120, 32'h0);
        chk("R6", {31'b0, irq_out[2]}, 32'h0);
        rd('h124, v); chk("R6", v, 32'h4);
        rd('h120, v); chk("R6", v, 32'h0);
        wr('h120, 32'h5);
        chk("R6", {31'b0, irq_out[2]}, 32'h1);
        src_lines[2*W + 2] = 1'b0;
        wr('h124, 32'h4);

        // R3: line already high when unmasked is not latched
        src_lines[3*W + 7] = 1'b1; tick();
        wr('h130, 32'h80);
        tick();
        rd('h134, v); chk("R3", v, 32'h0);
        chk("R1", {31'b0, irq_out[3]}, 32'h0);
        src_lines[3*W + 7] = 1'b0;

        // R7: plain storage
        wr('h000, 32'hA5A5A5A5);
        wr('h108, 32'h00001234);
        wr('h3D4, 32'hCAFEF00D);
        rd('h108, v); chk("R7", v, 32'h00001234);
        rd('h3D4, v); chk("R7", v, 32'hCAFEF00D);
        rd('h000, v); chk("R7", v, 32'hA5A5A5A5);
        tick();
        chk("R11", bus_rdata, 32'hA5A5A5A5);

        // R8: out of range
        wr('h3D8, 32'hFFFFFFFF);
        rd('h3D8, v); chk("R8", v, 32'h0);
        rd('h3FC, v); chk("R8", v, 32'h0);

        // R9: misaligned
        wr('h001, 32'hDEADBEEF);
        rd('h000, v); chk("R9", v, 32'hA5A5A5A5);
        rd('h001, v); chk("R9", v, 32'h0);

        // Random phase, checked every cycle against the reference state
        for (int n = 0; n < 4000; n++) begin
            for (int g = 0; g < G; g++)
                if ($urandom % 6 == 0)
                    src_lines[g*W + int'($urandom % W)] ^= 1'b1;
            case ($urandom % 8)
                0: wr(10'('h100 + 'h10 * ($urandom % G)), $urandom);
                1: wr(10'('h104 + 'h10 * ($urandom % G)),
                      ($urandom % 2 == 0) ? 32'hFFFFFFFF : $urandom);
                2: rd(10'('h100 + 'h10 * ($urandom % G) + 4 * ($urandom % 2)), v);
                3: wr(10'(4 * ($urandom % (LIM / 4))), $urandom);
                4: rd(10'(4 * ($urandom % 256)), v);
                5: if ($urandom % 2 == 0) wr(10'($urandom % 1024) | 10'h1, $urandom);
                   else rd(10'($urandom % 1024) | 10'h2, v);
                default: tick();
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule